// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block keeps a 16-bit running total driven by a single shared input pin. It has two modes. In edge-count mode it adds one for each edge of the selected polarity on the pin. In gated-time mode it adds one for each divide-by-64 tick from the main timer, but only while the pin holds its selected active level. In gated-time mode the end of the active level is reported as an input event. Because that tick comes from the timer prescaler, gated-time mode stops counting when the timer stops. Edge-count mode does not depend on the timer at all.

Software uses a small word-wide register bus with three registers: control, flags and count. The count can be read and loaded at any time. A wrap of the count raises an overflow flag, and a qualifying pin event raises an input flag. Each flag is cleared by writing one to its bit. A fast-clear control input lets any access to the count register clear both flags. Each flag drives an interrupt request through its own enable. The pin is brought into the clock domain through a synchronizer, so pulses on it must stay longer than two clocks.

Top module: `pacc_top`

## Requirements
- R1: After a synchronous active-low reset, the count, both flags, both interrupt requests and the control register (address 0) read as zero.
- R2: With enable (control bit 0) set, mode (bit 1) clear and polarity (bit 2) set, each rising pin edge adds one to the count, three clocks after the pin changes. Falling edges are not counted.
- R3: With enable set, mode clear and polarity clear, each falling pin edge adds one to the count. Rising edges are not counted.
- R4: With enable and mode set and polarity clear, each clock in which the tick input is high and the synchronized pin is high adds one, visible on the next clock. Ticks while the pin is low are not counted.
- R5: With enable, mode and polarity all set, ticks are counted while the pin is low and ignored while it is high.
- R6: The input flag (flag register bit 0) is set by a rising pin edge when polarity is set and by a falling pin edge when polarity is clear. In edge-count mode this is every counted edge. In gated-time mode it is the trailing edge of the active level.
- R7: An increment that takes the count from 0xFFFF to 0x0000 sets the overflow flag (flag register bit 1).
- R8: A write to the flag register (address 1) clears each flag whose data bit is one, on the next clock. Flags whose data bit is zero keep their value.
- R9: While the fast-clear input is high, any read or write of the count register (address 2) clears both flags. Reads of other addresses, or any access while fast-clear is low, leave the flags unchanged.
- R10: The input interrupt request equals the input flag gated by control bit 4. The overflow interrupt request equals the overflow flag gated by control bit 3.
- R11: While enable is clear, pin edges and ticks change neither the count nor the flags.
- R12: A write to address 2 loads the count on the next clock and can be read back at address 2. A load takes precedence over an increment in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 1 | Shared input pin, asynchronous |
| tick_div64 | input | 1 | One-clock divide-by-64 pulse from the timer prescaler |
| fast_clr | input | 1 | Fast flag clear control |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 flags, 2 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| count | output | 16 | Accumulator value |
| flag_in | output | 1 | Input event flag |
| flag_ovf | output | 1 | Overflow flag |
| irq_in | output | 1 | Input event interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A pin change reaches the count and the input flag three clocks after it is driven: two synchronizer stages, then the count and flag register. A tick, a bus write and a bus access that clears flags each take effect one clock after they are driven, and read data is valid in the same clock as the address. The driver task records each expectation with the exact cycle in which it is due. The monitor compares it in that cycle and fails any item that arrives early or late. For the pin path it also checks the cycle before the due cycle, which confirms the count has not yet moved.

// File: rtl/pacc_pkg.sv
// Shared definitions for the pulse accumulator: register addresses,
// flag bit positions and the control register layout.
// Assumes a two-bit word address on the register bus.
package pacc_pkg;
    localparam int ADDR_W       = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;
    localparam int FLAG_IN_BIT  = 0;
    localparam int FLAG_OVF_BIT = 1;

    // First member is the MSB: en sits at bit 0, ie_in at bit 4.
    typedef struct packed {
        logic ie_in;
        logic ie_ovf;
        logic pol;
        logic mode;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pacc_edge.sv
// Pin front end: brings the asynchronous pin into the clock domain
// through SYNC_STAGES flops and produces the level and one-clock
// rise/fall pulses. Assumes pin pulses are longer than SYNC_STAGES clocks.
module pacc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the pin through the synchronizer and keep one prior sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Level and edge pulses from the settled samples.
    always_comb begin
        lvl  = sync_q[SYNC_STAGES-1];
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
    end

    a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> !fall);
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pacc_counter.sv
// Accumulator register: adds one when enabled and stepped and loads
// from the bus (load wins). Reports a wrap from all-ones to zero.
module pacc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic adv;

    // Decide whether the count advances this clock.
    always_comb begin
        adv  = en & step & ~ld;
        wrap = adv & (cnt == ALL_ONES);
    end

    // Count register with bus load priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (adv) cnt <= cnt + ONE;
    end

    a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld) |=> $stable(cnt));
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE));
endmodule

// File: rtl/pacc_flags.sv
// Sticky flag pair: set by events, cleared by write-one-to-clear or by
// the fast clear strobe. A set in the same clock as a clear wins.
module pacc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic set_ovf,
    input  logic clr_in,
    input  logic clr_ovf,
    input  logic clr_all,
    output logic flag_in,
    output logic flag_ovf
);
    // Update both flags with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_in  <= 1'b0;
            flag_ovf <= 1'b0;
        end else begin
            flag_in  <= set_in  | (flag_in  & ~(clr_in  | clr_all));
            flag_ovf <= set_ovf | (flag_ovf & ~(clr_ovf | clr_all));
        end
    end

    a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> flag_ovf);
    a_r8_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in && !set_in) |=> !flag_in);
    a_r9_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !set_in && !set_ovf) |=> (!flag_in && !flag_ovf));
endmodule

// File: rtl/pacc_top.sv
// Dual-mode pulse accumulator. Edge-count mode counts pin edges of the
// selected polarity; gated-time mode counts timer ticks while the pin is
// at the active level. Assumes tick_div64 is a one-clock synchronous pulse.
module pacc_top #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pin_raw,
    input  logic                       tick_div64,
    input  logic                       fast_clr,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [pacc_pkg::ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]           bus_wdata,
    output logic [CNT_W-1:0]           bus_rdata,
    output logic [CNT_W-1:0]           count,
    output logic                       flag_in,
    output logic                       flag_ovf,
    output logic                       irq_in,
    output logic                       irq_ovf
);
    import pacc_pkg::*;

    ctrl_t ctrl_q;
    logic  lvl, rise, fall;
    logic  step, set_in, wrap;
    logic  wr_ctrl, wr_flag, wr_cnt, acc_cnt;

    // Bus decode.
    always_comb begin
        wr_ctrl = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
        wr_flag = bus_sel & bus_wr & (bus_addr == ADDR_FLAG);
        wr_cnt  = bus_sel & bus_wr & (bus_addr == ADDR_CNT);
        acc_cnt = bus_sel & (bus_addr == ADDR_CNT);
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    pacc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    // Count and input-flag qualification from mode and polarity.
    always_comb begin
        if (ctrl_q.mode) step = tick_div64 & (ctrl_q.pol ? ~lvl : lvl);
        else             step = ctrl_q.pol ? rise : fall;
        set_in = ctrl_q.en & (ctrl_q.pol ? rise : fall);
    end

    pacc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .step(step),
        .ld(wr_cnt), .ld_val(bus_wdata), .cnt(count), .wrap(wrap)
    );

    pacc_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_in(set_in), .set_ovf(wrap),
        .clr_in(wr_flag & bus_wdata[FLAG_IN_BIT]),
        .clr_ovf(wr_flag & bus_wdata[FLAG_OVF_BIT]),
        .clr_all(fast_clr & acc_cnt),
        .flag_in(flag_in), .flag_ovf(flag_ovf)
    );

    // Interrupt requests and read data.
    always_comb begin
        irq_in  = flag_in  & ctrl_q.ie_in;
        irq_ovf = flag_ovf & ctrl_q.ie_ovf;
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = CNT_W'(ctrl_q);
            ADDR_FLAG: begin
                bus_rdata[FLAG_IN_BIT]  = flag_in;
                bus_rdata[FLAG_OVF_BIT] = flag_ovf;
            end
            ADDR_CNT:  bus_rdata = count;
            default:   bus_rdata = '0;
        endcase
    end

    a_r10_irq_in_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |-> (flag_in && ctrl_q.ie_in));
    a_r10_irq_ovf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> (flag_ovf && ctrl_q.ie_ovf));
    a_r11_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !flag_in) |=> !flag_in);
endmodule

// File: tb/sim_pacc_top.sv
`timescale 1ns/100ps
module sim_pacc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_raw = 1'b0;
    logic        tick_div64 = 1'b0;
    logic        fast_clr = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata, count;
    logic        flag_in, flag_ovf, irq_in, irq_ovf;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // kind: 0 count, 1 flags {ovf,in}, 2 irqs {ovf,in}, 3 read data
    typedef struct {
        int          due;
        int          kind;
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t q[$];

    pacc_top u0 (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .tick_div64(tick_div64),
        .fast_clr(fast_clr), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .flag_in(flag_in), .flag_ovf(flag_ovf),
        .irq_in(irq_in), .irq_ovf(irq_ovf)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops every item due now and compares at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            logic [15:0] act;
            e = q.pop_front();
            case (e.kind)
                0: act = count;
                1: act = {14'd0, flag_ovf, flag_in};
                2: act = {14'd0, irq_ovf, irq_in};
                default: act = bus_rdata;
            endcase
            checks++;
            if (e.due != cyc || act !== e.val) begin
                errors++;
                $display("FAIL %s: kind %0d actual %h expected %h (cycle %0d due %0d)",
                         e.tag, e.kind, act, e.val, cyc, e.due);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Driver side: queue an expectation due DELAY cycles from now, in due order.
    task automatic chk(input int delay, input int kind, input logic [15:0] val, input string tag);
        exp_t e;
        int pos;
        e.due = cyc + delay; e.kind = kind; e.val = val; e.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due > e.due) begin pos = i; break; end
        end
        q.insert(pos, e);
    endtask

    task automatic drain();
        while (q.size() > 0) step();
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        step();
        bus_sel = 1'b0;
    endtask

    task automatic pulse_tick();
        tick_div64 = 1'b1; step();
        tick_div64 = 1'b0; step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 0, 16'h0, "R1 count"); chk(0, 1, 16'h0, "R1 flags");
        chk(0, 2, 16'h0, "R1 irqs");  chk(0, 3, 16'h0, "R1 control");
        drain();

        // R2 rising edges, three-clock latency
        bwrite(2'd0, 16'h0005);
        pin_raw = 1'b1;
        chk(2, 0, 16'd0, "R2 not yet"); chk(3, 0, 16'd1, "R2 rise");
        chk(3, 1, 16'h1, "R6 event flag"); drain();
        pin_raw = 1'b0;
        chk(4, 0, 16'd1, "R2 fall ignored"); drain();
        // R8 write-one-to-clear
        bwrite(2'd1, 16'h0002); chk(0, 1, 16'h1, "R8 other bit kept"); drain();
        bwrite(2'd1, 16'h0001); chk(0, 1, 16'h0, "R8 input cleared"); drain();

        // R3 falling edges
        bwrite(2'd0, 16'h0001);
        pin_raw = 1'b1; chk(4, 0, 16'd1, "R3 rise ignored"); drain();
        pin_raw = 1'b0; chk(3, 0, 16'd2, "R3 fall"); chk(3, 1, 16'h1, "R6 fall flag"); drain();
        bwrite(2'd1, 16'h0001);

        // R12 load and readback, load beats increment
        bwrite(2'd2, 16'h0005);
        chk(0, 0, 16'h5, "R12 load"); chk(0, 3, 16'h5, "R12 readback"); drain();
        pin_raw = 1'b1; chk(4, 0, 16'h5, "R3 rise ignored"); drain();
        pin_raw = 1'b0; step(); step();
        bwrite(2'd2, 16'h0010);
        chk(0, 0, 16'h0010, "R12 load wins"); chk(0, 1, 16'h1, "R6 flag on loaded edge"); drain();
        bwrite(2'd1, 16'h0001);

        // R4 gated by high level
        bwrite(2'd0, 16'h0003); bwrite(2'd2, 16'h0000);
        repeat (3) pulse_tick();
        chk(0, 0, 16'd0, "R4 low ignored"); drain();
        pin_raw = 1'b1; repeat (3) step();
        repeat (3) pulse_tick();
        chk(0, 0, 16'd3, "R4 high counted"); chk(0, 1, 16'h0, "R6 no flag on leading"); drain();
        pin_raw = 1'b0;
        chk(3, 1, 16'h1, "R6 trailing fall"); chk(3, 0, 16'd3, "R4 count held"); drain();
        bwrite(2'd1, 16'h0001);

        // R5 gated by low level
        bwrite(2'd0, 16'h0007); bwrite(2'd2, 16'h0000);
        repeat (2) pulse_tick();
        chk(0, 0, 16'd2, "R5 low counted"); drain();
        pin_raw = 1'b1;
        chk(3, 1, 16'h1, "R6 trailing rise"); drain();
        repeat (2) pulse_tick();
        chk(0, 0, 16'd2, "R5 high ignored"); drain();
        bwrite(2'd1, 16'h0001);

        // R7 wrap and R10 interrupts
        bwrite(2'd0, 16'h0019); bwrite(2'd2, 16'hFFFF);
        pin_raw = 1'b0;
        chk(2, 0, 16'hFFFF, "R7 before wrap"); chk(3, 0, 16'h0000, "R7 wrap");
        chk(3, 1, 16'h3, "R7 both flags"); chk(3, 2, 16'h3, "R10 both irqs"); drain();
        bwrite(2'd0, 16'h0001);
        chk(0, 2, 16'h0, "R10 irqs masked"); chk(0, 1, 16'h3, "R10 flags kept"); drain();

        // R9 fast clear
        bread(2'd2); chk(0, 1, 16'h3, "R9 off no clear"); drain();
        fast_clr = 1'b1;
        bread(2'd0); chk(0, 1, 16'h3, "R9 other addr"); drain();
        bread(2'd2); chk(0, 1, 16'h0, "R9 count access clears"); drain();
        fast_clr = 1'b0;

        // R11 disabled
        bwrite(2'd0, 16'h0000);
        pin_raw = 1'b1; repeat (4) step();
        pin_raw = 1'b0; pulse_tick();
        chk(5, 0, 16'h0, "R11 count held"); chk(5, 1, 16'h0, "R11 no flags"); drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule